// File: doc/BRIEF.md
# Card Command Issue and Response Capture Unit

This unit sits between a register port and a memory-card command engine. Software sets a 6-bit command index, a 32-bit argument made of two 16-bit halves, a block length, a block count and a control word. Writing the control word arms a command. The command goes to the card side once the card clock runs and the stop-transfer bit is clear. The card side answers through a request/acknowledge handshake. It returns a byte count and up to sixteen response bytes.

On the acknowledge, the unit compares the returned byte count with the response kind named in the control word. If the count is too short, it flags a response timeout. Otherwise it packs the bytes into nine 16-bit response words and marks the response as complete. When the control word enables data, it also hands the total byte count and the direction to the transfer engine. Software drains the response words one per read through a single register. Once the words are used up, that register reads zero.

Top module: `cmdresp_unit`

## Requirements
- R1: The command index register keeps 6 bits. A read returns the index with bit 6 set. The index is driven on `card_cmd` while a request is out.
- R2: The argument high (address 1) and low (address 2) registers each replace one 16-bit half and keep the other half. The full argument appears on `card_arg` while a request is out.
- R3: A write to the control register (address 3) keeps only the bits under mask 0x3DFF. It pulses `xfer_abort` for one cycle, arms a command, and clears status bits 1 and 13.
- R4: An armed command raises `card_req` one cycle after it is armed, provided `clk_on` is high and stop-transfer (control bit 10) is clear. With `clk_on` low, the command waits and is issued the cycle after `clk_on` rises. With bit 10 set, it is never issued.
- R5: `card_req` stays high until a cycle with `card_ack`, and it is low in the cycle after that acknowledge.
- R6: The response kind is control bits 1:0. Kind 0 accepts any count. Kinds 1 and 3 need at least 4 bytes, and kind 2 needs 16. A shortfall sets status bit 1 (status register, address 7), leaves bit 13 clear and gives no transfer load.
- R7: On an accepted response, word i is byte 2i in bits 7:0 and byte 2i+1 in bits 15:8. Bytes at or above the returned count read as zero, and status bit 13 is set. The read pointer returns to word 0.
- R8: Every acknowledged command pulses `end_cmd` for exactly one cycle, in the cycle after the acknowledge.
- R9: Each read of the response register (address 6) returns the next word and advances the pointer. After nine reads it returns zero.
- R10: The block length (address 4) keeps 12 bits and the block count (address 5) keeps 16 bits. If control bit 2 is set, an accepted response pulses `xfer_load` with `xfer_bytes` equal to count times length and `xfer_write` equal to control bit 3.
- R11: Issuing a command clears all response words to zero. A rejected response therefore reads back as zeros.
- R12: After reset all registers, status and outputs are zero. The command register reads 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid the next cycle |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered |
| clk_on | input | 1 | Card clock running |
| card_req | output | 1 | Command request to the card side |
| card_cmd | output | 6 | Command index of the outstanding request |
| card_arg | output | 32 | Argument of the outstanding request |
| card_ack | input | 1 | Response available |
| card_len | input | 5 | Number of response bytes returned (0 to 16) |
| card_resp | input | 128 | Response bytes, byte k at bits 8k+7:8k |
| end_cmd | output | 1 | One-cycle end-of-command event |
| xfer_abort | output | 1 | One-cycle stop of any active transfer |
| xfer_load | output | 1 | One-cycle load of the transfer byte count |
| xfer_write | output | 1 | Direction for the loaded transfer (1 = write) |
| xfer_bytes | output | 28 | Byte count for the loaded transfer |

## Verification
The hardest case to reach is a rejected response that follows an accepted one whose words were never read. In that case stale data and a pointer left at word 0 would show through if issuing failed to clear the words. The stimulus gets there with a directed command pair: a full long response that is left unread, then a long-kind command acknowledged with 15 bytes. A second awkward point is the wait for the clock. A command is armed with the clock off, held for several cycles, and the bench checks that the request rises exactly one cycle after the clock comes on. Random rounds mix response kinds, byte counts from 0 to 16, data enable, direction and block sizes.

// File: rtl/cmdresp_pkg.sv
package cmdresp_pkg;

    typedef enum logic [2:0] {
        SEL_CMD    = 3'd0,
        SEL_ARGH   = 3'd1,
        SEL_ARGL   = 3'd2,
        SEL_CTRL   = 3'd3,
        SEL_BLKLEN = 3'd4,
        SEL_BLKCNT = 3'd5,
        SEL_RESP   = 3'd6,
        SEL_STAT   = 3'd7
    } reg_sel_e;

    localparam int CTRL_W = 14;
    localparam logic [CTRL_W-1:0] CTRL_KEEP = 14'h3DFF;

    // control word fields decoded by the sequencer
    localparam int KIND_LO  = 0;
    localparam int DEN_BIT  = 2;
    localparam int WDIR_BIT = 3;
    localparam int STOP_BIT = 10;

    // status bits
    localparam int ST_TOUT_BIT   = 1;
    localparam int ST_ENDRES_BIT = 13;

    localparam logic [1:0] KIND_NONE = 2'd0;
    localparam logic [1:0] KIND_LONG = 2'd2;

    localparam int SHORT_RESP_BYTES = 4;

endpackage

// File: rtl/cmdresp_regs.sv
module cmdresp_regs
    import cmdresp_pkg::*;
#(
    parameter int CMD_W    = 6,
    parameter int DATA_W   = 16,
    parameter int BLKLEN_W = 12,
    parameter int BLKCNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [CMD_W-1:0]      cmd_idx,
    output logic [2*DATA_W-1:0]   arg,
    output logic [CTRL_W-1:0]     ctrl,
    output logic [BLKLEN_W-1:0]   blklen,
    output logic [BLKCNT_W-1:0]   blkcnt,
    output logic                  ctrl_wr,
    output logic [DATA_W-1:0]     rd_val
);

    localparam int ARG_W = 2 * DATA_W;

    typedef struct packed {
        logic [CMD_W-1:0]    cmd;
        logic [ARG_W-1:0]    arg;
        logic [CTRL_W-1:0]   ctrl;
        logic [BLKLEN_W-1:0] blklen;
        logic [BLKCNT_W-1:0] blkcnt;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (addr)
                SEL_CMD:    regs_d.cmd = wdata[CMD_W-1:0];
                SEL_ARGH:   regs_d.arg[ARG_W-1:DATA_W] = wdata;
                SEL_ARGL:   regs_d.arg[DATA_W-1:0] = wdata;
                SEL_CTRL:   regs_d.ctrl = wdata[CTRL_W-1:0] & CTRL_KEEP;
                SEL_BLKLEN: regs_d.blklen = wdata[BLKLEN_W-1:0];
                SEL_BLKCNT: regs_d.blkcnt = wdata[BLKCNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign cmd_idx = regs_q.cmd;
    assign arg     = regs_q.arg;
    assign ctrl    = regs_q.ctrl;
    assign blklen  = regs_q.blklen;
    assign blkcnt  = regs_q.blkcnt;
    assign ctrl_wr = wr_en && (addr == SEL_CTRL);

    always_comb begin
        rd_val = '0;
        case (addr)
            SEL_CMD: begin
                rd_val[CMD_W-1:0] = regs_q.cmd;
                rd_val[CMD_W]     = 1'b1;
            end
            SEL_ARGH:   rd_val = regs_q.arg[ARG_W-1:DATA_W];
            SEL_ARGL:   rd_val = regs_q.arg[DATA_W-1:0];
            SEL_CTRL:   rd_val[CTRL_W-1:0] = regs_q.ctrl;
            SEL_BLKLEN: rd_val[BLKLEN_W-1:0] = regs_q.blklen;
            SEL_BLKCNT: rd_val[BLKCNT_W-1:0] = regs_q.blkcnt;
            default: ;
        endcase
    end

    // R2
    arg_low_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_ARGH) |=> arg[DATA_W-1:0] == $past(arg[DATA_W-1:0]));

    // R2
    arg_high_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_ARGL) |=> arg[ARG_W-1:DATA_W] == $past(arg[ARG_W-1:DATA_W]));

endmodule

// File: rtl/cmdresp_seq.sv
module cmdresp_seq
    import cmdresp_pkg::*;
#(
    parameter int CMD_W      = 6,
    parameter int ARG_W      = 32,
    parameter int BLKLEN_W   = 12,
    parameter int BLKCNT_W   = 16,
    parameter int RESP_BYTES = 16,
    parameter int LEN_W      = $clog2(RESP_BYTES + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ctrl_wr,
    input  logic [1:0]                    kind,
    input  logic                          data_en,
    input  logic                          wdir,
    input  logic                          stop,
    input  logic                          clk_on,
    input  logic [CMD_W-1:0]              cmd_in,
    input  logic [ARG_W-1:0]              arg_in,
    input  logic [BLKLEN_W-1:0]           blklen,
    input  logic [BLKCNT_W-1:0]           blkcnt,
    input  logic                          card_ack,
    input  logic [LEN_W-1:0]              card_len,
    output logic                          card_req,
    output logic [CMD_W-1:0]              card_cmd,
    output logic [ARG_W-1:0]              card_arg,
    output logic                          issue,
    output logic                          capture,
    output logic                          tout,
    output logic                          endres,
    output logic                          end_cmd,
    output logic                          xfer_abort,
    output logic                          xfer_load,
    output logic                          xfer_write,
    output logic [BLKLEN_W+BLKCNT_W-1:0]  xfer_bytes
);

    localparam int BYTES_W = BLKLEN_W + BLKCNT_W;

    typedef struct packed {
        logic               pending;
        logic               req;
        logic               tout;
        logic               endres;
        logic               evt;
        logic               load;
        logic               abort;
        logic               wdir;
        logic [BYTES_W-1:0] bytes;
        logic [CMD_W-1:0]   cmd;
        logic [ARG_W-1:0]   arg;
    } seq_t;

    seq_t seq_d, seq_q;
    logic finish;
    logic len_ok;

    always_comb begin
        case (kind)
            KIND_NONE: len_ok = 1'b1;
            KIND_LONG: len_ok = (card_len >= LEN_W'(RESP_BYTES));
            default:   len_ok = (card_len >= LEN_W'(SHORT_RESP_BYTES));
        endcase
    end

    assign issue   = !seq_q.req && seq_q.pending && clk_on && !stop;
    assign finish  = seq_q.req && card_ack;
    assign capture = finish && len_ok;

    always_comb begin
        seq_d       = seq_q;
        seq_d.evt   = 1'b0;
        seq_d.load  = 1'b0;
        seq_d.abort = 1'b0;

        if (issue) begin
            seq_d.pending = 1'b0;
            seq_d.req     = 1'b1;
            seq_d.cmd     = cmd_in;
            seq_d.arg     = arg_in;
        end

        if (finish) begin
            seq_d.req = 1'b0;
            seq_d.evt = 1'b1;
            if (len_ok) begin
                seq_d.endres = 1'b1;
                if (data_en) begin
                    seq_d.load  = 1'b1;
                    seq_d.wdir  = wdir;
                    seq_d.bytes = BYTES_W'(blkcnt) * BYTES_W'(blklen);
                end
            end else begin
                seq_d.tout = 1'b1;
            end
        end

        if (ctrl_wr) begin
            seq_d.pending = 1'b1;
            seq_d.abort   = 1'b1;
            seq_d.tout    = 1'b0;
            seq_d.endres  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign card_req   = seq_q.req;
    assign card_cmd   = seq_q.cmd;
    assign card_arg   = seq_q.arg;
    assign tout       = seq_q.tout;
    assign endres     = seq_q.endres;
    assign end_cmd    = seq_q.evt;
    assign xfer_abort = seq_q.abort;
    assign xfer_load  = seq_q.load;
    assign xfer_write = seq_q.wdir;
    assign xfer_bytes = seq_q.bytes;

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (card_req && !card_ack) |=> card_req);

    // R5
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (card_req && card_ack) |=> !card_req);

    // R8
    evt_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_cmd |-> $past(card_req && card_ack));

    // R4
    issue_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_req) |-> ($past(clk_on) && !$past(stop)));

    // R6
    load_only_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_load |-> (endres && !tout));

    // R3
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !finish) |=> (xfer_abort && !tout && !endres));

endmodule

// File: rtl/cmdresp_fifo.sv
module cmdresp_fifo #(
    parameter int WORDS      = 9,
    parameter int RESP_BYTES = 16,
    parameter int LEN_W      = $clog2(RESP_BYTES + 1),
    parameter int PTR_W      = $clog2(WORDS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    capture,
    input  logic [LEN_W-1:0]        card_len,
    input  logic [8*RESP_BYTES-1:0] card_resp,
    input  logic                    pop,
    output logic [15:0]             rd_word
);

    localparam int FILL_WORDS = (RESP_BYTES + 1) / 2;

    typedef struct packed {
        logic [WORDS-1:0][15:0] words;
        logic [PTR_W-1:0]       ptr;
    } fifo_t;

    fifo_t fifo_d, fifo_q;
    logic [2*FILL_WORDS-1:0][7:0] kept;

    // each returned byte is kept only when it lies below the returned count
    for (genvar b = 0; b < 2 * FILL_WORDS; b++) begin : g_byte
        if (b < RESP_BYTES) begin : g_real
            assign kept[b] = (LEN_W'(b) < card_len) ? card_resp[8*b +: 8] : 8'h00;
        end else begin : g_pad
            assign kept[b] = 8'h00;
        end
    end

    always_comb begin
        fifo_d = fifo_q;
        if (clear) begin
            fifo_d.words = '0;
        end
        if (capture) begin
            for (int w = 0; w < WORDS; w++) begin
                if (w < FILL_WORDS) fifo_d.words[w] = {kept[2*w+1], kept[2*w]};
                else                fifo_d.words[w] = 16'h0000;
            end
            fifo_d.ptr = '0;
        end else if (pop && fifo_q.ptr < PTR_W'(WORDS)) begin
            fifo_d.ptr = fifo_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    always_comb begin
        rd_word = 16'h0000;
        for (int w = 0; w < WORDS; w++) begin
            if (fifo_q.ptr == PTR_W'(w)) rd_word = fifo_q.words[w];
        end
    end

    // R9
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_q.ptr <= PTR_W'(WORDS));

    // R9
    ptr_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !capture && fifo_q.ptr == PTR_W'(WORDS)) |=> fifo_q.ptr == PTR_W'(WORDS));

    // R7
    ptr_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> fifo_q.ptr == '0);

endmodule

// File: rtl/cmdresp_unit.sv
module cmdresp_unit
    import cmdresp_pkg::*;
#(
    parameter int CMD_W      = 6,
    parameter int DATA_W     = 16,
    parameter int BLKLEN_W   = 12,
    parameter int BLKCNT_W   = 16,
    parameter int RESP_WORDS = 9,
    parameter int RESP_BYTES = 16,
    parameter int LEN_W      = $clog2(RESP_BYTES + 1),
    parameter int BYTES_W    = BLKLEN_W + BLKCNT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [2:0]              reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    input  logic                    clk_on,
    output logic                    card_req,
    output logic [CMD_W-1:0]        card_cmd,
    output logic [2*DATA_W-1:0]     card_arg,
    input  logic                    card_ack,
    input  logic [LEN_W-1:0]        card_len,
    input  logic [8*RESP_BYTES-1:0] card_resp,
    output logic                    end_cmd,
    output logic                    xfer_abort,
    output logic                    xfer_load,
    output logic                    xfer_write,
    output logic [BYTES_W-1:0]      xfer_bytes
);

    localparam int ARG_W = 2 * DATA_W;

    logic [CMD_W-1:0]    cmd_idx;
    logic [ARG_W-1:0]    arg;
    logic [CTRL_W-1:0]   ctrl;
    logic [BLKLEN_W-1:0] blklen;
    logic [BLKCNT_W-1:0] blkcnt;
    logic                ctrl_wr;
    logic [DATA_W-1:0]   reg_val;
    logic                issue, capture, tout, endres;
    logic [15:0]         resp_word;
    logic                pop;

    cmdresp_regs #(
        .CMD_W(CMD_W), .DATA_W(DATA_W), .BLKLEN_W(BLKLEN_W), .BLKCNT_W(BLKCNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .cmd_idx(cmd_idx), .arg(arg), .ctrl(ctrl), .blklen(blklen), .blkcnt(blkcnt),
        .ctrl_wr(ctrl_wr), .rd_val(reg_val)
    );

    cmdresp_seq #(
        .CMD_W(CMD_W), .ARG_W(ARG_W), .BLKLEN_W(BLKLEN_W), .BLKCNT_W(BLKCNT_W),
        .RESP_BYTES(RESP_BYTES), .LEN_W(LEN_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .kind(ctrl[KIND_LO +: 2]), .data_en(ctrl[DEN_BIT]), .wdir(ctrl[WDIR_BIT]),
        .stop(ctrl[STOP_BIT]), .clk_on(clk_on),
        .cmd_in(cmd_idx), .arg_in(arg), .blklen(blklen), .blkcnt(blkcnt),
        .card_ack(card_ack), .card_len(card_len),
        .card_req(card_req), .card_cmd(card_cmd), .card_arg(card_arg),
        .issue(issue), .capture(capture), .tout(tout), .endres(endres),
        .end_cmd(end_cmd), .xfer_abort(xfer_abort), .xfer_load(xfer_load),
        .xfer_write(xfer_write), .xfer_bytes(xfer_bytes)
    );

    assign pop = reg_rd && (reg_addr == SEL_RESP);

    cmdresp_fifo #(
        .WORDS(RESP_WORDS), .RESP_BYTES(RESP_BYTES), .LEN_W(LEN_W)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(issue), .capture(capture),
        .card_len(card_len), .card_resp(card_resp), .pop(pop), .rd_word(resp_word)
    );

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t top_d, top_q;

    always_comb begin
        top_d = top_q;
        if (reg_rd) begin
            case (reg_addr)
                SEL_RESP: top_d.rdata = DATA_W'(resp_word);
                SEL_STAT: begin
                    top_d.rdata = '0;
                    top_d.rdata[ST_TOUT_BIT]   = tout;
                    top_d.rdata[ST_ENDRES_BIT] = endres;
                end
                default:  top_d.rdata = reg_val;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign reg_rdata = top_q.rdata;

    // R6
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tout && endres));

endmodule

// File: tb/cmdresp_unit_test.sv
module cmdresp_unit_test;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] A_CMD = 3'd0, A_ARGH = 3'd1, A_ARGL = 3'd2, A_CTRL = 3'd3,
                           A_BLEN = 3'd4, A_BCNT = 3'd5, A_RESP = 3'd6, A_STAT = 3'd7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [15:0]  reg_wdata = '0;
    logic [15:0]  reg_rdata;
    logic         clk_on = 1'b0;
    logic         card_req;
    logic [5:0]   card_cmd;
    logic [31:0]  card_arg;
    logic         card_ack = 1'b0;
    logic [4:0]   card_len = '0;
    logic [127:0] card_resp = '0;
    logic         end_cmd, xfer_abort, xfer_load, xfer_write;
    logic [27:0]  xfer_bytes;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    cmdresp_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_on(clk_on),
        .card_req(card_req), .card_cmd(card_cmd), .card_arg(card_arg),
        .card_ack(card_ack), .card_len(card_len), .card_resp(card_resp),
        .end_cmd(end_cmd), .xfer_abort(xfer_abort), .xfer_load(xfer_load),
        .xfer_write(xfer_write), .xfer_bytes(xfer_bytes)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    function automatic bit len_ok(input int kind, input int len);
        if (kind == 0) return 1'b1;
        if (kind == 2) return len >= 16;
        return len >= 4;
    endfunction

    function automatic logic [15:0] exp_word(input int w, input int len,
                                             input logic [127:0] v, input bit ok);
        logic [7:0] lo, hi;
        if (!ok || w >= 8) return 16'h0000;
        lo = (2 * w < len) ? v[16*w +: 8] : 8'h00;
        hi = (2 * w + 1 < len) ? v[16*w + 8 +: 8] : 8'h00;
        return {hi, lo};
    endfunction

    // acknowledge an outstanding request and check everything that follows
    task automatic respond(input int kind, input bit den, input bit wd, input int len,
                           input logic [127:0] v, input logic [11:0] bl,
                           input logic [15:0] bc, input int nread);
        bit ok;
        logic [15:0] r;
        ok = len_ok(kind, len);
        card_ack = 1'b1; card_len = 5'(len); card_resp = v;
        @(negedge clk);
        card_ack = 1'b0;
        chk("R8 end_cmd after ack", 32'(end_cmd), 32'd1);
        chk("R5 req dropped after ack", 32'(card_req), 32'd0);
        chk("R10 xfer_load", 32'(xfer_load), 32'(ok && den));
        if (ok && den) begin
            chk("R10 xfer_bytes", 32'(xfer_bytes), 32'(bl) * 32'(bc));
            chk("R10 xfer_write", 32'(xfer_write), 32'(wd));
        end
        @(negedge clk);
        chk("R8 end_cmd one cycle", 32'(end_cmd), 32'd0);
        rd(A_STAT, r);
        chk(ok ? "R7 status end-response" : "R6 status timeout", 32'(r),
            ok ? 32'h2000 : 32'h0002);
        for (int w = 0; w < nread; w++) begin
            rd(A_RESP, r);
            chk("R9 response word", 32'(r), 32'(exp_word(w, len, v, ok)));
        end
    endtask

    task automatic do_cmd(input int kind, input bit den, input bit wd, input int len,
                          input logic [127:0] v, input logic [11:0] bl,
                          input logic [15:0] bc, input int nread);
        wr(A_BLEN, 16'(bl));
        wr(A_BCNT, bc);
        wr(A_CTRL, 16'(kind) | (16'(den) << 2) | (16'(wd) << 3));
        chk("R4 no request in write cycle", 32'(card_req), 32'd0);
        @(negedge clk);
        chk("R4 request one cycle after arm", 32'(card_req), 32'd1);
        respond(kind, den, wd, len, v, bl, bc, nread);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        logic [127:0] v;
        void'($urandom(32'd4321));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        chk("R12 card_req reset", 32'(card_req), 32'd0);
        chk("R12 end_cmd reset", 32'(end_cmd), 32'd0);
        chk("R12 xfer_load reset", 32'(xfer_load), 32'd0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), r);
            chk("R12 register reset", 32'(r), (a == 0) ? 32'h40 : 32'h0);
        end

        // R1 command register
        wr(A_CMD, 16'hFFFF);
        rd(A_CMD, r);
        chk("R1 cmd keeps 6 bits", 32'(r), 32'h7F);
        wr(A_CMD, 16'h0011);
        rd(A_CMD, r);
        chk("R1 cmd readback flag", 32'(r), 32'h51);

        // R2 argument halves
        wr(A_ARGH, 16'hBEEF);
        wr(A_ARGL, 16'h1234);
        wr(A_ARGH, 16'hCAFE);
        rd(A_ARGH, r);
        chk("R2 arg high", 32'(r), 32'hCAFE);
        rd(A_ARGL, r);
        chk("R2 arg low kept", 32'(r), 32'h1234);

        // R4 clock off: command waits
        clk_on = 1'b0;
        wr(A_CTRL, 16'h0001);
        repeat (5) @(negedge clk);
        chk("R4 held while clock off", 32'(card_req), 32'd0);
        clk_on = 1'b1;
        @(negedge clk);
        chk("R4 issued after clock on", 32'(card_req), 32'd1);
        chk("R1 card_cmd", 32'(card_cmd), 32'h11);
        chk("R2 card_arg", card_arg, 32'hCAFE1234);
        respond(1, 1'b0, 1'b0, 4, 128'h0000_0000_0000_0000_0000_0000_A1B2_C3D4,
                12'd0, 16'd0, 3);

        // R3 control write: mask, abort, status clear; R4 stop bit blocks issue
        wr(A_CTRL, 16'hFFFF);
        chk("R3 abort pulse", 32'(xfer_abort), 32'd1);
        @(negedge clk);
        chk("R3 abort one cycle", 32'(xfer_abort), 32'd0);
        rd(A_CTRL, r);
        chk("R3 ctrl mask", 32'(r), 32'h3DFF);
        rd(A_STAT, r);
        chk("R3 status cleared", 32'(r), 32'h0);
        repeat (6) @(negedge clk);
        chk("R4 stop bit blocks issue", 32'(card_req), 32'd0);

        // R10 field widths
        wr(A_BLEN, 16'hFFFF);
        rd(A_BLEN, r);
        chk("R10 block length 12 bits", 32'(r), 32'hFFF);

        // R6 kind checks
        v = {$urandom, $urandom, $urandom, $urandom};
        do_cmd(2, 1'b1, 1'b0, 15, v, 12'h200, 16'd4, 10);
        do_cmd(2, 1'b1, 1'b1, 16, v, 12'hFFF, 16'hFFFF, 10);
        do_cmd(3, 1'b1, 1'b0, 3, v, 12'h010, 16'd2, 10);
        do_cmd(0, 1'b1, 1'b1, 0, v, 12'h001, 16'd1, 10);
        do_cmd(0, 1'b0, 1'b0, 5, v, 12'h001, 16'd1, 10);

        // R11 accepted response left unread, then a rejected one reads zeros
        do_cmd(2, 1'b0, 1'b0, 16, v, 12'h0, 16'h0, 0);
        do_cmd(2, 1'b0, 1'b0, 15, v, 12'h0, 16'h0, 0);
        for (int w = 0; w < 9; w++) begin
            rd(A_RESP, r);
            chk("R11 cleared after issue", 32'(r), 32'h0);
        end

        // random rounds
        for (int i = 0; i < 30; i++) begin
            int kind, len;
            kind = int'($urandom_range(3, 0));
            len  = int'($urandom_range(16, 0));
            if ($urandom_range(3, 0) == 0) len = (kind == 2) ? 16 : 4;
            v = {$urandom, $urandom, $urandom, $urandom};
            do_cmd(kind, 1'($urandom), 1'($urandom), len, v,
                   12'($urandom), 16'($urandom), 10);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule